// File: doc/BRIEF.md
# I2C Master Bus Command Engine

This block drives the clock and data lines of an I2C master one bus operation at a time. Software writes a small control register. Its command field, qualified by the acknowledge field, selects a START, a repeated START or a STOP condition. Writing the data register shifts one byte onto the bus, most significant bit first, followed by a ninth clock on which the slave's acknowledge is sampled. The sampled acknowledge is returned in the same register bit that qualifies the start command.

Each finished operation raises a session-done flag. A busy flag covers the span from acceptance to completion, and writes that arrive during that span are dropped. A divider makes quarter-bit ticks, and the default count gives a standard-mode bit rate from a 50 MHz clock. The pads are open-drain and appear as pull-low enables, plus a sampled data input.

Top module: `i2c_cmd_engine`

## Requirements
- R1: After reset both pad enables are 0 (lines released), busy and done read 0, and the control readback is 4'b0000.
- R2: Control layout: bit 0 enable, bits 2:1 command (0 no action, 1 start/restart, 2 stop, 3 no action), bit 3 acknowledge field. An accepted write reads back unchanged until an operation updates bit 3.
- R3: Command 1 with bit 3 = 0 pulls SDA low while SCL is high, then pulls SCL low.
- R4: Command 1 with bit 3 = 1 releases SDA while SCL is low, releases SCL, pulls SDA low while SCL is high, then pulls SCL low.
- R5: Command 2 pulls SDA low with SCL low, releases SCL, then releases SDA while SCL is high, leaving both lines released.
- R6: A data write with enable set sends the 8 bits MSB first. SDA changes only while SCL is low. A ninth clock follows with SDA released.
- R7: After a byte, control bit 3 reads 1 if SDA was high on the ninth clock (NAK) and 0 if it was low (ACK).
- R8: Busy is 1 from the cycle after acceptance until completion. Completion sets done. Done stays set until done_clr_i, and it is cleared when a new operation is accepted.
- R9: A control or data write while busy is ignored: no bus activity follows from it and the control fields keep their values.
- R10: With the enable bit clear, a command write starts no operation, and a data write is ignored.
- R11: Pad enables change only on quarter-bit ticks every QTR_CYC clocks, so SCL is released for 2*QTR_CYC clocks per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_we_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | 4 | Control write value {ack, cmd[1:0], en} |
| ctrl_rdata_o | output | 4 | Control readback {ack, cmd[1:0], en} |
| data_we_i | input | 1 | Data register write strobe, starts a byte |
| data_wdata_i | input | 8 | Byte to transmit |
| done_clr_i | input | 1 | Clears the session-done flag |
| done_o | output | 1 | Session-done flag |
| busy_o | output | 1 | Operation in progress |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe_o | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The bench builds the engine with QTR_CYC = 3, so a whole byte takes 108 clocks and a full START, bytes, repeated START and STOP session fits in a few hundred cycles. A quarter period that short still spans several clocks. That makes the 6-clock SCL high window measurable, and it leaves room to inject a second write while an operation is still busy. The default of 125 keeps the same sequencing at a 100 kHz bit rate and only stretches the waiting.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_START   = 3'd1,
    OP_RESTART = 3'd2,
    OP_STOP    = 3'd3,
    OP_BYTE    = 3'd4
  } op_e;

  localparam logic [1:0] CMD_NONE  = 2'd0;
  localparam logic [1:0] CMD_BEGIN = 2'd1;
  localparam logic [1:0] CMD_STOP  = 2'd2;

  localparam int unsigned BYTE_BITS   = 8;
  localparam int unsigned QTR_PER_BIT = 4;
endpackage

// File: rtl/i2c_qtr_div.sv
module i2c_qtr_div #(
  parameter int unsigned QTR_CYC = 125
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == LAST);

  // R11
  tick_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/i2c_bus_seq.sv
module i2c_bus_seq
  import i2c_cmd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  op_e        op_i,
  input  logic [7:0] byte_i,
  input  logic       tick_i,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o,
  output logic       done_o,
  output logic       nak_upd_o,
  output logic       nak_o
);
  localparam int unsigned BYTE_STEPS = (BYTE_BITS + 1) * QTR_PER_BIT;
  localparam int unsigned SW = $clog2(BYTE_STEPS);

  op_e          op_q;
  logic [SW-1:0] step_q;
  logic [7:0]   sh_q;
  logic [SW-1:0] last_step;
  logic [SW-3:0] bit_idx;
  logic [1:0]   phase;

  assign bit_idx = step_q[SW-1:2];
  assign phase   = step_q[1:0];

  always_comb begin
    unique case (op_q)
      OP_START:   last_step = SW'(1);
      OP_RESTART: last_step = SW'(3);
      OP_STOP:    last_step = SW'(2);
      OP_BYTE:    last_step = SW'(BYTE_STEPS - 1);
      default:    last_step = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q      <= OP_IDLE;
      step_q    <= '0;
      sh_q      <= '0;
      scl_oe_o  <= 1'b0;
      sda_oe_o  <= 1'b0;
      done_o    <= 1'b0;
      nak_upd_o <= 1'b0;
      nak_o     <= 1'b0;
    end else begin
      done_o    <= 1'b0;
      nak_upd_o <= 1'b0;
      if (op_q == OP_IDLE) begin
        if (go_i) begin
          op_q   <= op_i;
          step_q <= '0;
          sh_q   <= byte_i;
        end
      end else if (tick_i) begin
        unique case (op_q)
          OP_START: begin
            if (step_q == '0) sda_oe_o <= 1'b1;
            else              scl_oe_o <= 1'b1;
          end
          OP_RESTART: begin
            unique case (phase)
              2'd0: sda_oe_o <= 1'b0;
              2'd1: scl_oe_o <= 1'b0;
              2'd2: sda_oe_o <= 1'b1;
              default: scl_oe_o <= 1'b1;
            endcase
          end
          OP_STOP: begin
            unique case (phase)
              2'd0: sda_oe_o <= 1'b1;
              2'd1: scl_oe_o <= 1'b0;
              default: sda_oe_o <= 1'b0;
            endcase
          end
          default: begin
            unique case (phase)
              2'd0: sda_oe_o <= (bit_idx < (SW-2)'(BYTE_BITS)) ? ~sh_q[7] : 1'b0;
              2'd1: scl_oe_o <= 1'b0;
              2'd2: if (bit_idx == (SW-2)'(BYTE_BITS)) nak_o <= sda_i;
              default: begin
                scl_oe_o <= 1'b1;
                sh_q     <= {sh_q[6:0], 1'b0};
              end
            endcase
          end
        endcase
        if (step_q == last_step) begin
          op_q      <= OP_IDLE;
          done_o    <= 1'b1;
          nak_upd_o <= (op_q == OP_BYTE);
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  // R11
  pads_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> ($stable(scl_oe_o) && $stable(sda_oe_o)));

  // R6
  sda_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_BYTE && !scl_oe_o) |=> $stable(sda_oe_o));
endmodule

// File: rtl/i2c_cmd_engine.sv
module i2c_cmd_engine
  import i2c_cmd_pkg::*;
#(
  parameter int unsigned QTR_CYC = 125
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ctrl_we_i,
  input  logic [3:0] ctrl_wdata_i,
  output logic [3:0] ctrl_rdata_o,
  input  logic       data_we_i,
  input  logic [7:0] data_wdata_i,
  input  logic       done_clr_i,
  output logic       done_o,
  output logic       busy_o,
  input  logic       sda_i,
  output logic       scl_oe_o,
  output logic       sda_oe_o
);
  logic       en_q, ack_q, busy_q, done_q;
  logic [1:0] cmd_q;
  logic       ctrl_acc, ctrl_go, data_go, go;
  logic       tick, seq_done, nak_upd, nak;
  op_e        op_sel;

  assign ctrl_acc = ctrl_we_i && !busy_q;
  assign ctrl_go  = ctrl_acc && ctrl_wdata_i[0] &&
                    (ctrl_wdata_i[2:1] == CMD_BEGIN || ctrl_wdata_i[2:1] == CMD_STOP);
  assign data_go  = data_we_i && !ctrl_we_i && !busy_q && en_q;
  assign go       = ctrl_go || data_go;

  always_comb begin
    if (data_go)                          op_sel = OP_BYTE;
    else if (ctrl_wdata_i[2:1] == CMD_STOP) op_sel = OP_STOP;
    else if (ctrl_wdata_i[3])             op_sel = OP_RESTART;
    else                                  op_sel = OP_START;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      cmd_q  <= CMD_NONE;
      ack_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (ctrl_acc) begin
        en_q  <= ctrl_wdata_i[0];
        cmd_q <= ctrl_wdata_i[2:1];
        ack_q <= ctrl_wdata_i[3];
      end else if (nak_upd) begin
        ack_q <= nak;
      end
      if (go)            busy_q <= 1'b1;
      else if (seq_done) busy_q <= 1'b0;
      if (seq_done)        done_q <= 1'b1;
      else if (go)         done_q <= 1'b0;
      else if (done_clr_i) done_q <= 1'b0;
    end
  end

  i2c_qtr_div #(.QTR_CYC(QTR_CYC)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy_q),
    .tick_o (tick)
  );

  i2c_bus_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (go),
    .op_i      (op_sel),
    .byte_i    (data_wdata_i),
    .tick_i    (tick),
    .sda_i     (sda_i),
    .scl_oe_o  (scl_oe_o),
    .sda_oe_o  (sda_oe_o),
    .done_o    (seq_done),
    .nak_upd_o (nak_upd),
    .nak_o     (nak)
  );

  assign ctrl_rdata_o = {ack_q, cmd_q, en_q};
  assign done_o       = done_q;
  assign busy_o       = busy_q;

  // R9
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && ctrl_we_i) |=> ($stable(cmd_q) && $stable(en_q)));

  // R8
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> !done_q);

  // R10
  idle_pads_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |=> ($stable(scl_oe_o) && $stable(sda_oe_o)));
endmodule

// File: tb/tb_i2c_cmd_engine.sv
module tb_i2c_cmd_engine;
  localparam int unsigned QTR = 3;
  localparam logic [8:0] VEC [0:3] = '{9'h0A5, 9'h13C, 9'h0FF, 9'h100};

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_we = 1'b0, data_we = 1'b0, done_clr = 1'b0;
  logic [3:0] ctrl_wdata = '0, ctrl_rdata;
  logic [7:0] data_wdata = '0;
  logic done, busy, scl_oe, sda_oe;
  logic scl_w, sda_w, slave_pull = 1'b0;
  logic mon_on = 1'b0, byte_mode = 1'b0, slave_nak = 1'b0;
  int   bitcnt = 0, hi_w = 0, start_cnt = 0, stop_cnt = 0;
  logic [15:0] rx = '0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  assign scl_w = ~scl_oe;
  assign sda_w = ~(sda_oe | slave_pull);

  i2c_cmd_engine #(.QTR_CYC(QTR)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata), .ctrl_rdata_o(ctrl_rdata),
    .data_we_i(data_we), .data_wdata_i(data_wdata),
    .done_clr_i(done_clr), .done_o(done), .busy_o(busy),
    .sda_i(sda_w), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  always @(negedge sda_w) if (mon_on && scl_w) start_cnt++;
  always @(posedge sda_w) if (mon_on && scl_w) stop_cnt++;
  always @(posedge scl_w) if (byte_mode) begin rx = {rx[14:0], sda_w}; bitcnt++; end
  always @(negedge scl_w) if (byte_mode) begin
    if (bitcnt == 8 && !slave_nak) slave_pull = 1'b1;
    if (bitcnt == 9) slave_pull = 1'b0;
  end
  always @(negedge clk) if (byte_mode && scl_w && bitcnt == 1) hi_w++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [3:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic wr_data(input logic [7:0] v);
    @(negedge clk); data_we = 1'b1; data_wdata = v;
    @(negedge clk); data_we = 1'b0;
  endtask

  task automatic clr_done();
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 1000) begin @(negedge clk); n++; end
    chk(req, {31'd0, done}, 32'd1);
  endtask

  task automatic arm(input logic nak);
    rx = '0; bitcnt = 0; hi_w = 0; slave_nak = nak; slave_pull = 1'b0; byte_mode = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int s0, p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;
    // R1
    chk("R1 ctrl", ctrl_rdata, 4'h0);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 scl", scl_oe, 0);
    chk("R1 sda", sda_oe, 0);

    // R3 start, with R9 writes dropped while busy
    wr_ctrl(4'b0011);
    chk("R8 busy", busy, 1);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = 4'b0101;
    @(negedge clk); ctrl_we = 1'b0; data_we = 1'b1; data_wdata = 8'h55;
    @(negedge clk); data_we = 1'b0;
    wait_done("R8 start done");
    chk("R8 not busy", busy, 0);
    chk("R3 start event", start_cnt, 1);
    chk("R3 scl low", scl_oe, 1);
    chk("R3 sda low", sda_oe, 1);
    chk("R9 no stop", stop_cnt, 0);
    chk("R2 R9 ctrl", ctrl_rdata, 4'b0011);
    repeat (20) @(negedge clk);
    chk("R9 no byte", {31'd0, scl_oe & sda_oe}, 1);
    chk("R8 done held", done, 1);
    clr_done();
    chk("R8 done clr", done, 0);
    wr_ctrl(4'b0001);
    chk("R2 noaction", ctrl_rdata, 4'b0001);
    chk("R2 noaction busy", busy, 0);

    // R6 R7 R11 vector walk
    for (int i = 0; i < 4; i++) begin
      s0 = start_cnt; p0 = stop_cnt;
      arm(VEC[i][8]);
      wr_data(VEC[i][7:0]);
      chk("R8 byte busy", busy, 1);
      wait_done("R8 byte done");
      chk("R6 byte", rx[8:1], VEC[i][7:0]);
      chk("R6 nine clocks", bitcnt, 9);
      chk("R7 ack bit", ctrl_rdata[3], VEC[i][8]);
      chk("R6 no cond", start_cnt - s0 + stop_cnt - p0, 0);
      chk("R11 scl high", hi_w, 2 * QTR);
      byte_mode = 1'b0;
      clr_done();
    end

    // R4 repeated start
    s0 = start_cnt; p0 = stop_cnt;
    wr_ctrl(4'b1011);
    wait_done("R4 done");
    chk("R4 start event", start_cnt - s0, 1);
    chk("R4 no stop", stop_cnt - p0, 0);
    chk("R4 scl low", scl_oe, 1);
    chk("R4 sda low", sda_oe, 1);
    chk("R2 restart readback", ctrl_rdata, 4'b1011);
    clr_done();

    // R5 stop
    wr_ctrl(4'b0101);
    wait_done("R5 done");
    chk("R5 stop event", stop_cnt - p0, 1);
    chk("R5 scl rel", scl_oe, 0);
    chk("R5 sda rel", sda_oe, 0);
    clr_done();

    // R10 enable clear
    s0 = start_cnt;
    wr_ctrl(4'b0010);
    chk("R10 cmd busy", busy, 0);
    chk("R2 R10 readback", ctrl_rdata, 4'b0010);
    wr_data(8'h81);
    chk("R10 data busy", busy, 0);
    repeat (30) @(negedge clk);
    chk("R10 no start", start_cnt - s0, 0);
    chk("R10 scl", scl_oe, 0);
    chk("R10 sda", sda_oe, 0);

    // R2 reserved code 3
    wr_ctrl(4'b0111);
    chk("R2 code3 busy", busy, 0);
    repeat (20) @(negedge clk);
    chk("R2 code3 pads", {30'd0, scl_oe, sda_oe}, 0);
    chk("R2 code3 done", done, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule